// File: doc/BRIEF.md
# Probe Contact Alignment Sequencer

This controller sits on the test-fixture FPGA and brings a bare sensor die into reliable contact with a two-pin-per-pad probe card before the die is ever powered. Every pad is touched by a drive needle and a twin sense needle. A pulse sent out on the drive needle comes back on the sense needle only when both needles touch the pad. The sequencer uses that loop to decide when the chuck has been raised far enough.

After a start request, the block keeps the supply relay open. It pulses all digital-input pads at once and asks for coarse chuck raises until any pad loops back. It then pulses the digital pads one at a time and asks for fine raises until every one loops back. A second one-at-a-time pass follows, and a configuration input can skip it. Next comes the supply check. The block places a pull-down on the sense needles of supply pads and a pull-up on those of ground pads, stops driving every drive needle, and closes the supply relay. It asks for fine raises until each supply sense reads high and each ground sense reads low. Finally it disconnects the sense needles of analog pads and re-reads the supply and ground contacts at a fixed period.

Each pad's role comes from a type table that is captured while reset is held. A 4-bit state code drives the LED display. Raise requests use a request/done handshake. Two raise budgets guard against a die that never makes contact: one covers coarse raises, the other covers each fine phase.

Top module: `probe_contact_seq`

## Requirements
- R1: While `rst_n` is low, the block captures `pad_type_i`, two bits per pad with pad k in bits [2k+1:2k]. The codes are 0 = digital input, 1 = supply, 2 = ground, 3 = analog. Out of reset, `led_o` is 0, the supply relay is open, no drive needle is enabled, no raise is requested, and `done_o` and `fault_o` are low.
- R2: In the coarse phase (LED code 2), every digital pad is driven high at the same time. If no digital sense needle returns high, the block requests a raise with `raise_fine_o` low (LED code 3). As soon as any digital sense needle returns high, it moves to the fine phase.
- R3: In the fine phase (LED code 4), at most one drive needle is enabled at a time. After a full pass in which any digital pad failed to loop back, the block requests a fine raise (LED code 5) and repeats the pass.
- R4: When `skip_second_i` is 0, a second one-at-a-time pass (LED codes 6 and 7) follows the fine phase. When it is 1, that pass never occurs.
- R5: `raise_req_o` stays high until `raise_done_i` is seen. No drive needle is enabled while a raise is requested.
- R6: If a raise is needed after COARSE_LIMIT coarse raises, or after FINE_LIMIT raises within one fine-type phase, the block enters FAULT (LED code 15, `fault_o` high). In FAULT the relay is open, no needle is driven, and no pulls are on. FAULT holds until reset.
- R7: The supply relay closes only after the supply-pad pull-downs and ground-pad pull-ups are on (LED codes 8, 9, 10 in that order). No drive needle is enabled while the relay is closed.
- R8: In the supply check (LED code 11), a supply pad must read high and a ground pad must read low. On any mismatch the block requests a fine raise (LED code 12) and checks again.
- R9: On success, `sense_en_o` goes low for analog pads only and `done_o` rises (LED code 14). The supply and ground sense needles are then re-read every CHECK_PERIOD cycles into `pad_status_o`, with bit k set meaning pad k is out of contact. `contact_ok_o` is high when no bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset; pad types captured while low |
| start_i | input | 1 | begin a contact sequence from idle |
| skip_second_i | input | 1 | omit the second one-at-a-time pass |
| pad_type_i | input | 2*N | per-pad role codes |
| pin_b_i | input | N | sense needle levels |
| raise_done_i | input | 1 | stage finished the requested raise |
| pin_a_o | output | N | drive needle levels |
| pin_a_oe_o | output | N | drive needle enables |
| pull_dn_o | output | N | pull-down enable per sense needle |
| pull_up_o | output | N | pull-up enable per sense needle |
| sense_en_o | output | N | sense needle connected |
| pwr_relay_o | output | 1 | supply relay closed |
| raise_req_o | output | 1 | chuck raise request |
| raise_fine_o | output | 1 | requested raise is a fine step |
| pad_status_o | output | N | per-pad mismatch from the latest check |
| contact_ok_o | output | 1 | monitoring with all contacts good |
| led_o | output | 4 | state code for the display |
| done_o | output | 1 | sequence finished, monitoring |
| fault_o | output | 1 | raise budget exhausted |

## Verification
A wrong phase transition shows on the LED code, and on the count of coarse or fine raise handshakes, within one pulse pass of the fault. A bad relay or pull ordering is visible in the very cycle the relay closes. A stale per-pad mismatch bit or a wrong pad-type decode appears as a wrong pass or fail decision, which changes the raise counts. In monitoring, a bad contact has to reach `pad_status_o` within one CHECK_PERIOD, so a broken timer shows as a status that never updates.

// File: rtl/probe_contact_seq.sv
module probe_contact_seq #(
  parameter int N            = 103,
  parameter int SETTLE       = 15,
  parameter int COARSE_LIMIT = 8,
  parameter int FINE_LIMIT   = 32,
  parameter int CHECK_PERIOD = 1000000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           skip_second_i,
  input  logic [2*N-1:0] pad_type_i,
  input  logic [N-1:0]   pin_b_i,
  input  logic           raise_done_i,
  output logic [N-1:0]   pin_a_o,
  output logic [N-1:0]   pin_a_oe_o,
  output logic [N-1:0]   pull_dn_o,
  output logic [N-1:0]   pull_up_o,
  output logic [N-1:0]   sense_en_o,
  output logic           pwr_relay_o,
  output logic           raise_req_o,
  output logic           raise_fine_o,
  output logic [N-1:0]   pad_status_o,
  output logic           contact_ok_o,
  output logic [3:0]     led_o,
  output logic           done_o,
  output logic           fault_o
);

  localparam int IW   = (N > 1) ? $clog2(N) : 1;
  localparam int SW   = $clog2(SETTLE + 1);
  localparam int MAXL = (COARSE_LIMIT > FINE_LIMIT) ? COARSE_LIMIT : FINE_LIMIT;
  localparam int RW   = $clog2(MAXL + 1);
  localparam int TW   = $clog2(CHECK_PERIOD + 1);
  localparam logic [RW-1:0] CLIM = RW'(COARSE_LIMIT);
  localparam logic [RW-1:0] FLIM = RW'(FINE_LIMIT);

  typedef enum logic [3:0] {
    S_IDLE    = 4'd0,  S_OPEN   = 4'd1,  S_COARSE = 4'd2,  S_CRAISE  = 4'd3,
    S_FINE    = 4'd4,  S_FRAISE = 4'd5,  S_FINE2  = 4'd6,  S_F2RAISE = 4'd7,
    S_PULL    = 4'd8,  S_TRI    = 4'd9,  S_PWRON  = 4'd10, S_PCHK    = 4'd11,
    S_PRAISE  = 4'd12, S_RELEASE= 4'd13, S_MON    = 4'd14, S_FAULT   = 4'd15
  } state_t;

  state_t          st;
  logic [2*N-1:0]  ptype;
  logic [N-1:0]    dig, pwr, gnd, ana;
  logic [IW-1:0]   idx;
  logic [SW-1:0]   scnt;
  logic [RW-1:0]   rcnt;
  logic [TW-1:0]   tmr;
  logic            pass_err;
  logic [N-1:0]    status;

  always_ff @(posedge clk)
    if (!rst_n) ptype <= pad_type_i;

  for (genvar g = 0; g < N; g++) begin : g_decode
    assign dig[g] = ptype[2*g +: 2] == 2'd0;
    assign pwr[g] = ptype[2*g +: 2] == 2'd1;
    assign gnd[g] = ptype[2*g +: 2] == 2'd2;
    assign ana[g] = ptype[2*g +: 2] == 2'd3;
  end

  wire          settled    = scnt == SW'(SETTLE);
  wire          last       = idx == IW'(N - 1);
  wire          cur_dig    = dig[idx];
  wire          pad_err    = ~pin_b_i[idx];
  wire          fine_ph    = (st == S_FINE) || (st == S_FINE2);
  wire          step       = !cur_dig || settled;
  wire          bad_now    = pass_err | (cur_dig & pad_err);
  wire [N-1:0]  onehot     = N'(1) << idx;
  wire [N-1:0]  coarse_err = dig & ~pin_b_i;
  wire          echo       = |(dig & pin_b_i);
  wire [N-1:0]  pwr_err    = (pwr & ~pin_b_i) | (gnd & pin_b_i);
  wire          at_lim     = rcnt == ((st == S_COARSE) ? CLIM : FLIM);
  wire          pulled     = (st >= S_PULL) && (st != S_FAULT);
  wire          released   = (st == S_RELEASE) || (st == S_MON);
  wire          tick       = tmr == TW'(CHECK_PERIOD - 1);

  assign pin_a_oe_o   = (st == S_COARSE) ? dig : (fine_ph && cur_dig) ? onehot : '0;
  assign pin_a_o      = pin_a_oe_o;
  assign pull_dn_o    = pulled ? pwr : '0;
  assign pull_up_o    = pulled ? gnd : '0;
  assign sense_en_o   = released ? ~ana : '1;
  assign pwr_relay_o  = (st >= S_PWRON) && (st != S_FAULT);
  assign raise_req_o  = (st == S_CRAISE) || (st == S_FRAISE) || (st == S_F2RAISE) || (st == S_PRAISE);
  assign raise_fine_o = raise_req_o && (st != S_CRAISE);
  assign pad_status_o = status;
  assign done_o       = st == S_MON;
  assign fault_o      = st == S_FAULT;
  assign contact_ok_o = done_o && (status == '0);
  assign led_o        = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      scnt     <= '0;
      rcnt     <= '0;
      tmr      <= '0;
      pass_err <= 1'b0;
      status   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st     <= S_OPEN;
          status <= '0;
        end
        S_OPEN: begin
          st   <= S_COARSE;
          scnt <= '0;
          rcnt <= '0;
        end
        S_COARSE:
          if (!settled) scnt <= scnt + 1'b1;
          else begin
            scnt   <= '0;
            status <= coarse_err;
            if (echo || dig == '0) begin
              st       <= S_FINE;
              rcnt     <= '0;
              idx      <= '0;
              pass_err <= 1'b0;
            end else if (at_lim) st <= S_FAULT;
            else begin
              rcnt <= rcnt + 1'b1;
              st   <= S_CRAISE;
            end
          end
        S_FINE, S_FINE2:
          if (!step) scnt <= scnt + 1'b1;
          else begin
            scnt        <= '0;
            status[idx] <= cur_dig & pad_err;
            if (!last) begin
              idx      <= idx + 1'b1;
              pass_err <= bad_now;
            end else begin
              idx      <= '0;
              pass_err <= 1'b0;
              if (bad_now) begin
                if (at_lim) st <= S_FAULT;
                else begin
                  rcnt <= rcnt + 1'b1;
                  st   <= (st == S_FINE) ? S_FRAISE : S_F2RAISE;
                end
              end else begin
                rcnt <= '0;
                st   <= (st == S_FINE && !skip_second_i) ? S_FINE2 : S_PULL;
              end
            end
          end
        S_CRAISE:  if (raise_done_i) st <= S_COARSE;
        S_FRAISE:  if (raise_done_i) st <= S_FINE;
        S_F2RAISE: if (raise_done_i) st <= S_FINE2;
        S_PULL:    st <= S_TRI;
        S_TRI:     st <= S_PWRON;
        S_PWRON: begin
          st   <= S_PCHK;
          scnt <= '0;
        end
        S_PCHK:
          if (!settled) scnt <= scnt + 1'b1;
          else begin
            scnt   <= '0;
            status <= pwr_err;
            if (pwr_err == '0) st <= S_RELEASE;
            else if (at_lim) st <= S_FAULT;
            else begin
              rcnt <= rcnt + 1'b1;
              st   <= S_PRAISE;
            end
          end
        S_PRAISE:  if (raise_done_i) st <= S_PCHK;
        S_RELEASE: begin
          st  <= S_MON;
          tmr <= '0;
        end
        S_MON:
          if (tick) begin
            tmr    <= '0;
            status <= pwr_err;
          end else tmr <= tmr + 1'b1;
        default: st <= S_FAULT;
      endcase
    end
  end

endmodule

// File: rtl/probe_contact_seq_chk.sv
module probe_contact_seq_chk #(
  parameter int N = 103
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pin_a_oe_o,
  input logic [N-1:0] pull_dn_o,
  input logic         pwr_relay_o,
  input logic         raise_req_o,
  input logic         raise_done_i,
  input logic [3:0]   led_o,
  input logic         fault_o
);

  assert_one_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (led_o == 4'd4 || led_o == 4'd6) |-> $onehot0(pin_a_oe_o));

  assert_no_drive_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_relay_o |-> (pin_a_oe_o == '0));

  assert_relay_after_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_relay_o) |-> $past(led_o) == 4'd9);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_req_o && !raise_done_i) |=> raise_req_o);

  assert_quiet_in_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    raise_req_o |-> (pin_a_oe_o == '0));

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);

  assert_fault_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!pwr_relay_o && pin_a_oe_o == '0 && pull_dn_o == '0 && led_o == 4'd15));

endmodule

bind probe_contact_seq probe_contact_seq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_a_oe_o(pin_a_oe_o), .pull_dn_o(pull_dn_o),
  .pwr_relay_o(pwr_relay_o), .raise_req_o(raise_req_o), .raise_done_i(raise_done_i),
  .led_o(led_o), .fault_o(fault_o)
);

// File: tb/test_probe_contact_seq.sv
module test_probe_contact_seq;
  localparam int N = 6;
  localparam int PERIOD = 50;
  localparam logic [2*N-1:0] PT = {2'd0, 2'd3, 2'd2, 2'd1, 2'd0, 2'd0};
  localparam logic [N-1:0] PWR_M = 6'b000100;
  localparam logic [N-1:0] GND_M = 6'b001000;
  localparam logic [N-1:0] ANA_M = 6'b010000;

  logic clk = 0, rst_n = 0, start = 0, skip = 0, rdone = 0;
  logic [N-1:0] pin_b, pa, poe, pdn, pup, sen, status;
  logic relay, rreq, rfine, ok, done, fault;
  logic [3:0] led;

  int h, thr[N], coarse_n, fine_n, dly;
  bit seen2, seen4, seen6, viol_oe, viol_pull;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  probe_contact_seq #(.N(N), .SETTLE(3), .COARSE_LIMIT(3), .FINE_LIMIT(3), .CHECK_PERIOD(PERIOD))
  i_probe_contact_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .skip_second_i(skip), .pad_type_i(PT),
    .pin_b_i(pin_b), .raise_done_i(rdone), .pin_a_o(pa), .pin_a_oe_o(poe),
    .pull_dn_o(pdn), .pull_up_o(pup), .sense_en_o(sen), .pwr_relay_o(relay),
    .raise_req_o(rreq), .raise_fine_o(rfine), .pad_status_o(status),
    .contact_ok_o(ok), .led_o(led), .done_o(done), .fault_o(fault));

  always_comb
    for (int i = 0; i < N; i++) begin
      logic c;
      c = h >= thr[i];
      case (PT[2*i +: 2])
        2'd0:    pin_b[i] = c & poe[i] & pa[i];
        2'd1:    pin_b[i] = c & relay;
        2'd2:    pin_b[i] = c ? 1'b0 : pup[i];
        default: pin_b[i] = 1'b0;
      endcase
    end

  always @(posedge clk)
    if (!rst_n) begin
      rdone <= 0;
      dly <= 0;
    end else if (rdone) begin
      rdone <= 0;
      dly <= 0;
    end else if (rreq) begin
      if (dly == 2) begin
        rdone <= 1;
        h <= h + (rfine ? 1 : 4);
        if (rfine) fine_n <= fine_n + 1; else coarse_n <= coarse_n + 1;
      end else dly <= dly + 1;
    end

  always @(negedge clk) begin
    if (led == 4'd2) seen2 = 1;
    if (led == 4'd4) seen4 = 1;
    if (led == 4'd6) seen6 = 1;
    if (relay && poe != 0) viol_oe = 1;
    if (relay && (pdn != PWR_M || pup != GND_M)) viol_pull = 1;
  end

  task automatic check(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(int t0, int t1, int t5, int tp, int tg, bit sk);
    rst_n = 0;
    h = 0;
    thr[0] = t0; thr[1] = t1; thr[5] = t5; thr[2] = tp; thr[3] = tg; thr[4] = 0;
    skip = sk;
    coarse_n = 0; fine_n = 0;
    seen2 = 0; seen4 = 0; seen6 = 0; viol_oe = 0; viol_pull = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_seq();
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 3000 && !done && !fault; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    restart(4, 5, 6, 6, 7, 0);
    check(led == 0, "R1 led", led, 0);
    check(!relay && poe == 0 && !rreq, "R1 outputs quiet", {relay, rreq}, 0);
    check(!done && !fault, "R1 flags", {done, fault}, 0);
  endtask

  task automatic t_normal();
    restart(4, 5, 6, 6, 7, 0);
    run_seq();
    check(done && led == 4'd14, "R9 done led", led, 14);
    check(coarse_n == 1, "R2 coarse raises", coarse_n, 1);
    check(fine_n == 3, "R3 R8 fine raises", fine_n, 3);
    check(seen2 && seen4, "R2 R3 phase codes", {seen2, seen4}, 3);
    check(seen6, "R4 second pass present", seen6, 1);
    check(!viol_oe, "R7 no drive with relay", viol_oe, 0);
    check(!viol_pull, "R7 pulls before relay", viol_pull, 0);
    check(relay && pdn == PWR_M && pup == GND_M, "R7 pulls", pdn, PWR_M);
    check(sen == ~ANA_M, "R9 analog released", sen, ~ANA_M);
    check(status == 0 && ok, "R8 status clean", status, 0);
  endtask

  task automatic t_monitor();
    h = 6;
    repeat (PERIOD + 4) @(negedge clk);
    check(status == GND_M && !ok, "R9 ground loss seen", status, GND_M);
    h = 7;
    repeat (PERIOD + 4) @(negedge clk);
    check(status == 0 && ok, "R9 contact restored", status, 0);
  endtask

  task automatic t_coarse_fault();
    restart(100, 100, 100, 100, 100, 0);
    run_seq();
    check(fault && led == 4'd15, "R6 coarse fault", led, 15);
    check(coarse_n == 3 && fine_n == 0, "R6 coarse budget", coarse_n, 3);
    repeat (10) @(negedge clk);
    check(fault && !relay && poe == 0 && !rreq, "R6 fault safe and sticky", {relay, rreq}, 0);
  endtask

  task automatic t_fine_fault();
    restart(4, 100, 6, 6, 7, 0);
    run_seq();
    check(fault && led == 4'd15, "R6 fine fault", led, 15);
    check(coarse_n == 1 && fine_n == 3, "R6 fine budget", fine_n, 3);
  endtask

  task automatic t_skip();
    restart(0, 0, 0, 0, 0, 1);
    run_seq();
    check(done, "R4 skip completes", done, 1);
    check(!seen6, "R4 second pass skipped", seen6, 0);
    check(coarse_n == 0 && fine_n == 0, "R2 immediate echo no raise", coarse_n + fine_n, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_monitor();
    t_coarse_fault();
    t_fine_fault();
    t_skip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule